// File: doc/BRIEF.md
# Fall-Through Strobe-Handshake FIFO

This block is a first-in first-out queue of 64 words of 4 bits. A producer loads words with a shift-in strobe, and a consumer removes them with a shift-out strobe. The oldest stored word moves to the output bus on its own, with no read command. Two ready flags give the handshake. Input-ready tells the producer that a word can be accepted. Output-ready tells the consumer that the bus carries a word that has not yet been taken.

Both strobes are sampled by one system clock. Shift-out is edge-detected against a registered copy, so a word leaves the queue on the falling edge of that strobe. Shift-in is accepted once per high pulse, in the first cycle it is seen high while input-ready is high. After a word is taken, the output bus keeps it until the next word is loaded or reset is applied. When the queue is full and the producer holds its strobe high, the word is captured as soon as a slot frees. When the queue is empty and the consumer holds its strobe high, an arriving word still reaches the bus. In both cases the matching flag shows a one-cycle pulse.

Top module: `ftf_fifo`

## Requirements
- R1: While rst_ni is low, and after it is released, the queue is empty, in_rdy_o is 1, out_rdy_o is 0 and data_o is 0.
- R2: A word on data_i is captured in the first cycle that shift_in_i is sampled high while in_rdy_o is 1. Holding shift_in_i high for further cycles captures nothing more.
- R3: Words come out in the order they were written. When a word is written into an empty queue, it is loaded onto data_o, with out_rdy_o set, one clock after shift_in_i is sampled low.
- R4: The queue holds 64 words. A shift-in pulse that starts and ends while the queue is full changes neither the contents nor the order.
- R5: in_rdy_o goes low on the clock that captures a word. It stays low while shift_in_i remains high and while the queue is full.
- R6: out_rdy_o goes low one clock after shift_out_i is sampled high, and it is low while the queue is empty. The head word is removed on the clock that sees shift_out_i low after it was high. Shift-out pulses while the queue is empty have no effect.
- R7: After the head word is removed, data_o keeps that word until another word is loaded or reset is applied.
- R8: If shift_out_i is held high while a word falls through into an empty queue, out_rdy_o is high for exactly one clock. That word is removed on the later falling edge of shift_out_i.
- R9: If the queue is full and shift_in_i is held high, removing a word raises in_rdy_o for exactly one clock. The waiting data_i word is then appended at the tail of the queue.
- R10: If shift_in_i is high when rst_ni is released, the data_i word is captured and in_rdy_o stays low until shift_in_i goes low. If shift_in_i went low before the release, nothing is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples both strobes |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| data_i | input | 4 | Word to be written |
| shift_in_i | input | 1 | Shift-in strobe; a word is accepted once per high pulse |
| shift_out_i | input | 1 | Shift-out strobe; its falling edge removes the head word |
| data_o | output | 4 | Head word, or the last removed word |
| in_rdy_o | output | 1 | Queue can accept a word |
| out_rdy_o | output | 1 | data_o holds a word that has not yet been removed |

## Verification
A wrong occupancy count shows up at the ports in two ways. input-ready stays low too early, or fails to fall, on the 64th write. output-ready stays high, or fails to rise, on the last read. Both appear within two clocks of the strobe that causes them. Pointer or ordering faults show when the queue is drained, as a mismatch on the very next word. A broken hold or acknowledge flag turns a ready pulse into zero or two cycles, and a per-cycle count of each flag catches this. The output-hold rule is checked by repeating empty reads and then comparing the bus with the last word removed.

// File: rtl/ftf_pkg.sv
package ftf_pkg;
  typedef struct packed {
    logic push;
    logic load;
  } ftf_op_t;

  function automatic int unsigned ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ftf_strobe_edge.sv
module ftf_strobe_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign fall_o = strobe_q & ~strobe_i;
endmodule

// File: rtl/ftf_ram.sv
module ftf_ram #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o
);
  localparam int unsigned PW = ftf_pkg::ptr_w(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_en_i) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  assign rd_data_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/ftf_ctrl.sv
module ftf_ctrl #(
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_in_i,
  input  logic             shift_out_i,
  input  logic             so_fall_i,
  output ftf_pkg::ftf_op_t op_o,
  output logic             in_rdy_o,
  output logic             out_rdy_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] mem_cnt_q, mem_cnt_d, total_q, total_d;
  logic head_vld_q, head_vld_d;
  logic in_rdy_q, in_rdy_d;
  logic out_rdy_q, out_rdy_d;
  logic ack_q, ack_d;    // current shift-in pulse already consumed
  logic hold_q, hold_d;  // word written into empty queue waits for strobe low
  logic full, push, load, pop_head;

  assign total_q  = mem_cnt_q + CW'(head_vld_q);
  assign full     = (total_q == FULL_CNT);

  assign push     = shift_in_i & in_rdy_q & ~ack_q & ~full;
  assign pop_head = so_fall_i & head_vld_q;
  assign load     = ~head_vld_q & (mem_cnt_q != '0) & ~(hold_q & shift_in_i);

  always_comb begin
    mem_cnt_d  = mem_cnt_q + CW'(push) - CW'(load);
    head_vld_d = load | (head_vld_q & ~pop_head);
    total_d    = mem_cnt_d + CW'(head_vld_d);
    ack_d      = push | (ack_q & shift_in_i);
    hold_d     = (push & (total_q == '0)) | (hold_q & shift_in_i);
    in_rdy_d   = ~ack_d & (total_d != FULL_CNT);
    out_rdy_d  = load | (out_rdy_q & head_vld_d & ~shift_out_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_cnt_q  <= '0;
      head_vld_q <= 1'b0;
      in_rdy_q   <= 1'b1;
      out_rdy_q  <= 1'b0;
      ack_q      <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      mem_cnt_q  <= mem_cnt_d;
      head_vld_q <= head_vld_d;
      in_rdy_q   <= in_rdy_d;
      out_rdy_q  <= out_rdy_d;
      ack_q      <= ack_d;
      hold_q     <= hold_d;
    end
  end

  assign op_o.push = push;
  assign op_o.load = load;
  assign in_rdy_o  = in_rdy_q;
  assign out_rdy_o = out_rdy_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni) total_q <= FULL_CNT); // R4
  AST_FULL_BLOCKS_IN: assert property (@(posedge clk_i) disable iff (!rst_ni) full |-> !in_rdy_q); // R5
  AST_IN_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni) push |=> !in_rdy_q); // R5
  AST_EMPTY_NO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni) (total_q == '0) |-> !out_rdy_q); // R6
  AST_OUT_RDY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni) (out_rdy_q && shift_out_i) |=> !out_rdy_q); // R6
  AST_EMPTY_WRITE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni) (push && total_q == '0) |=> !out_rdy_q); // R3
endmodule

// File: rtl/ftf_fifo.sv
module ftf_fifo #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_in_i,
  input  logic             shift_out_i,
  output logic [WIDTH-1:0] data_o,
  output logic             in_rdy_o,
  output logic             out_rdy_o
);
  ftf_pkg::ftf_op_t op;
  logic             so_fall;
  logic [WIDTH-1:0] rd_data;
  logic [WIDTH-1:0] data_q;

  ftf_strobe_edge u_so_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (shift_out_i),
    .fall_o   (so_fall)
  );

  ftf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .shift_in_i  (shift_in_i),
    .shift_out_i (shift_out_i),
    .so_fall_i   (so_fall),
    .op_o        (op),
    .in_rdy_o    (in_rdy_o),
    .out_rdy_o   (out_rdy_o)
  );

  ftf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (op.push),
    .wr_data_i (data_i),
    .rd_en_i   (op.load),
    .rd_data_o (rd_data)
  );

  // head register: keeps the last word after removal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (op.load) data_q <= rd_data;
  end

  assign data_o = data_q;

  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !op.load |=> $stable(data_o)); // R7
endmodule

// File: tb/sim_ftf_fifo.sv
module sim_ftf_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] data_i = '0;
  logic       shift_in_i = 1'b0;
  logic       shift_out_i = 1'b0;
  logic [3:0] data_o;
  logic       in_rdy_o, out_rdy_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ftf_fifo u0 (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .data_i      (data_i),
    .shift_in_i  (shift_in_i),
    .shift_out_i (shift_out_i),
    .data_o      (data_o),
    .in_rdy_o    (in_rdy_o),
    .out_rdy_o   (out_rdy_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [3:0] w);
    data_i = w; shift_in_i = 1'b1;
    tick(1);
    shift_in_i = 1'b0;
    tick(1);
  endtask

  task automatic pop();
    shift_out_i = 1'b1;
    tick(1);
    shift_out_i = 1'b0;
    tick(2);
  endtask

  function automatic logic [3:0] pat(input int i);
    return 4'((i * 7 + 3) % 16);
  endfunction

  task automatic t_reset();
    tick(2);
    chk("R1 in_rdy in reset", in_rdy_o, 1);
    chk("R1 out_rdy in reset", out_rdy_o, 0);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 in_rdy after reset", in_rdy_o, 1);
    chk("R1 out_rdy after reset", out_rdy_o, 0);
    chk("R1 data_o after reset", data_o, 0);
  endtask

  task automatic t_order();
    data_i = 4'h5; shift_in_i = 1'b1;
    tick(1);
    chk("R5 in_rdy low after capture", in_rdy_o, 0);
    tick(2);
    chk("R3 no fall-through while strobe high", out_rdy_o, 0);
    shift_in_i = 1'b0;
    tick(1);
    chk("R3 first word falls through", data_o, 5);
    chk("R3 out_rdy set", out_rdy_o, 1);
    chk("R5 in_rdy back high", in_rdy_o, 1);
    push(4'hA);
    push(4'h3);
    shift_out_i = 1'b1;
    tick(1);
    chk("R6 out_rdy drops while strobe high", out_rdy_o, 0);
    chk("R6 head kept until falling edge", data_o, 5);
    shift_out_i = 1'b0;
    tick(2);
    chk("R3 second word", data_o, 4'hA);
    chk("R6 out_rdy after advance", out_rdy_o, 1);
    pop();
    chk("R3 third word", data_o, 3);
    pop();
    chk("R6 empty after last read", out_rdy_o, 0);
    chk("R7 last word retained", data_o, 3);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++) push(pat(i));
    chk("R4 in_rdy low when full", in_rdy_o, 0);
    push(4'hF);
    chk("R4 in_rdy still low", in_rdy_o, 0);
    for (int i = 0; i < DEPTH; i++) begin
      chk($sformatf("R4 drain word %0d", i), data_o, pat(i));
      if (out_rdy_o !== 1'b1) chk("R6 out_rdy during drain", out_rdy_o, 1);
      pop();
    end
    chk("R4 empty after 64 reads", out_rdy_o, 0);
    pop();
    pop();
    chk("R6 extra reads keep out_rdy low", out_rdy_o, 0);
    chk("R7 extra reads keep last word", data_o, pat(DEPTH - 1));
    chk("R6 in_rdy after extra reads", in_rdy_o, 1);
    push(4'h9);
    chk("R6 queue intact after empty reads", data_o, 9);
    chk("R6 out_rdy after refill", out_rdy_o, 1);
    pop();
  endtask

  task automatic t_or_pulse();
    int highs = 0;
    shift_out_i = 1'b1;
    tick(1);
    data_i = 4'h6; shift_in_i = 1'b1;
    tick(1);
    shift_in_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (out_rdy_o) highs++;
    end
    chk("R8 out_rdy single pulse", highs, 1);
    chk("R8 word on bus", data_o, 6);
    shift_out_i = 1'b0;
    tick(2);
    chk("R8 word removed on falling edge", out_rdy_o, 0);
    push(4'h2);
    chk("R8 next word follows", data_o, 2);
    pop();
  endtask

  task automatic t_ir_pulse();
    int highs = 0;
    for (int i = 0; i < DEPTH; i++) push(pat(i + 5));
    data_i = 4'hC; shift_in_i = 1'b1;
    tick(2);
    chk("R9 in_rdy low while full", in_rdy_o, 0);
    shift_out_i = 1'b1;
    tick(1);
    shift_out_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      if (in_rdy_o) highs++;
    end
    chk("R9 in_rdy single pulse", highs, 1);
    shift_in_i = 1'b0;
    tick(2);
    chk("R9 full again", in_rdy_o, 0);
    for (int i = 1; i < DEPTH; i++) begin
      if (data_o !== pat(i + 5)) chk($sformatf("R9 drain word %0d", i), data_o, pat(i + 5));
      pop();
    end
    chk("R9 auto-captured word last", data_o, 4'hC);
    pop();
    chk("R9 empty at end", out_rdy_o, 0);
  endtask

  task automatic t_reset_si();
    push(4'h4);
    push(4'h8);
    rst_ni = 1'b0;
    tick(1);
    chk("R1 reset clears data_o", data_o, 0);
    chk("R1 reset clears out_rdy", out_rdy_o, 0);
    data_i = 4'hB; shift_in_i = 1'b1;
    tick(1);
    rst_ni = 1'b1;
    tick(1);
    chk("R10 in_rdy low after capture at release", in_rdy_o, 0);
    tick(3);
    chk("R10 in_rdy held low while strobe high", in_rdy_o, 0);
    shift_in_i = 1'b0;
    tick(1);
    chk("R10 captured word on bus", data_o, 4'hB);
    chk("R10 in_rdy back high", in_rdy_o, 1);
    pop();
    chk("R2 held strobe captured one word", out_rdy_o, 0);
    rst_ni = 1'b0;
    data_i = 4'h7; shift_in_i = 1'b1;
    tick(1);
    shift_in_i = 1'b0;
    tick(1);
    rst_ni = 1'b1;
    tick(3);
    chk("R10 nothing captured", out_rdy_o, 0);
    chk("R10 data_o zero", data_o, 0);
    chk("R10 in_rdy high", in_rdy_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_order();
    t_full();
    t_or_pulse();
    t_ir_pulse();
    t_reset_si();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule